// File: doc/BRIEF.md
# Trimmed 32 kHz to 1 Hz Divider

This block turns a 32,768 Hz clock enable into a one-second tick for the timekeeping counters. It has two stages. The first stage divides the enable by 128 to make a 256 Hz stream. The second stage counts that stream down to 1 Hz. Crystal error is removed digitally, between the two stages. During a fixed correction window of 64 minutes, a number of the 256 Hz pulses are either dropped, which slows the clock, or doubled, which speeds it up. The number of pulses affected is set by a signed trim setting.

The trim setting is a six-bit control word. Its low five bits give a magnitude m from 0 to 31. Bit 5 gives the direction. The block corrects the first 2·m first-stage pulses of each window and leaves the rest of the window unchanged. A new setting is picked up only at a window boundary, so the count inside a window is never disturbed. A stop input freezes the whole chain, and the chain resumes from the held state when stop is released. Both the one-second tick and the corrected 256 Hz stream are outputs; the 256 Hz stream is there for test and measurement. All pins are plain control and status signals. No streamed data passes through the block, so there is no valid/ready handshake and no back-pressure.

The divide ratios and the window length are parameters. The defaults are PRE_DIV=128, POST_DIV=256 and WINDOW_SEC=3840.

Top module: `osc_trim_divider`

## Requirements
- R1: With trim magnitude 0, tick_cal pulses once every PRE_DIV active enables, and tick_1hz pulses once every PRE_DIV·POST_DIV active enables (32,768 with the default parameters).
- R2: An active enable is a cycle with en_32k=1 and stop=0. Only active enables advance the chain. Each output pulse lasts one cycle and appears in the clock cycle after the active enable that produced it.
- R3: A correction window is WINDOW_SEC·POST_DIV first-stage pulses long. In each window, the first 2·m first-stage pulses are corrected, where m is trim_cfg[4:0]. All later pulses in the window pass unchanged.
- R4: With trim_cfg[5]=0 (slow down), a corrected first-stage pulse is blanked. It produces no tick_cal pulse, and the second stage does not count it.
- R5: With trim_cfg[5]=1 (speed up), a corrected first-stage pulse is split. It is passed on, and a second pulse follows PRE_DIV/2 active enables later. Both pulses appear on tick_cal and both are counted.
- R6: trim_cfg is sampled on the last first-stage pulse of a window and applies from the next window. A change in the middle of a window has no effect on that window. The first window after reset uses no correction.
- R7: While stop=1, all state is held and no pulse is emitted. After release, dividing resumes from the held state.
- R8: Reset (rst_n=0, asynchronous) clears every counter and the pending split, and drives both outputs low.
- R9: tick_1hz is high only together with tick_cal, on every POST_DIV-th corrected pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_32k | input | 1 | 32,768 Hz clock enable, one cycle wide |
| stop | input | 1 | Freezes the divider while high |
| trim_cfg | input | 6 | [4:0] trim magnitude, [5] direction (1 speeds up, 0 slows down) |
| tick_1hz | output | 1 | One-cycle tick once per corrected second |
| tick_cal | output | 1 | Corrected first-stage pulse stream (test output) |

## Verification
The bench checks the window boundary directly. A trim setting applied before the first boundary must leave the first window uncorrected. A change in the middle of the next window must not alter that window's pulse count. A design that loads the setting at once would miscount both windows. Exact pulse counts per window, one count for each direction, expose a wrong budget of 2·m corrections, a blank that is still counted, and a split that is lost or issued twice. Stop bursts, idle enables and a reset in the middle of the run, mixed with random enable patterns, catch a chain that advances or emits while frozen, or that loses its phase across a stop.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int TRIM_MAG_W = 5;
  localparam int TRIM_W     = TRIM_MAG_W + 1;

  // bit 5 selects speed-up, bits 4:0 carry the magnitude
  typedef struct packed {
    logic                  speed_up;
    logic [TRIM_MAG_W-1:0] mag;
  } trim_t;

  typedef enum logic [1:0] {
    ACT_PASS  = 2'd0,
    ACT_BLANK = 2'd1,
    ACT_SPLIT = 2'd2
  } trim_act_e;
endpackage

// File: rtl/osc_prescaler.sv
module osc_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic raw_stb,
  output logic mid_stb
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam logic [W-1:0] HALF = W'(DIV / 2 - 1);

  logic [W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (step) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign raw_stb = step && (phase == LAST);
  assign mid_stb = step && (phase == HALF);
endmodule

// File: rtl/trim_window.sv
module trim_window
  import osc_trim_pkg::*;
#(
  parameter int WIN_LEN = 983040
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  raw_stb,
  input  trim_t                 cfg_in,
  output trim_act_e             act,
  output trim_t                 cfg_act,
  output logic                  wrap_stb,
  output logic [TRIM_MAG_W:0]   done_cnt
);
  localparam int WW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0]       win_pos;
  logic [TRIM_MAG_W:0] budget;
  logic                qualify;

  assign budget   = {cfg_act.mag, 1'b0};
  assign qualify  = raw_stb && (done_cnt < budget);
  assign wrap_stb = raw_stb && (win_pos == WIN_LAST);

  always_comb begin
    act = ACT_PASS;
    if (qualify) begin
      act = cfg_act.speed_up ? ACT_SPLIT : ACT_BLANK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_pos  <= '0;
      done_cnt <= '0;
      cfg_act  <= '0;
    end else if (raw_stb) begin
      if (wrap_stb) begin
        win_pos  <= '0;
        done_cnt <= '0;
        cfg_act  <= cfg_in;
      end else begin
        win_pos <= win_pos + 1'b1;
        if (qualify) begin
          done_cnt <= done_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pulse_corrector.sv
module pulse_corrector
  import osc_trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_stb,
  input  logic      mid_stb,
  input  trim_act_e act,
  output logic      corr_stb,
  output logic      split_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_pend <= 1'b0;
    end else if (raw_stb && act == ACT_SPLIT) begin
      split_pend <= 1'b1;
    end else if (mid_stb && split_pend) begin
      split_pend <= 1'b0;
    end
  end

  assign corr_stb = (raw_stb && act != ACT_BLANK) || (mid_stb && split_pend);
endmodule

// File: rtl/second_counter.sv
module second_counter #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic sec_stb
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (pulse) begin
      count <= (count == LAST) ? '0 : count + 1'b1;
    end
  end

  assign sec_stb = pulse && (count == LAST);
endmodule

// File: rtl/osc_trim_divider.sv
module osc_trim_divider
  import osc_trim_pkg::*;
#(
  parameter int PRE_DIV    = 128,
  parameter int POST_DIV   = 256,
  parameter int WINDOW_SEC = 3840
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_32k,
  input  logic              stop,
  input  logic [TRIM_W-1:0] trim_cfg,
  output logic              tick_1hz,
  output logic              tick_cal
);
  localparam int WIN_LEN = WINDOW_SEC * POST_DIV;

  logic                step;
  logic                raw_stb;
  logic                mid_stb;
  trim_act_e           act;
  trim_t               cfg_act;
  logic                wrap_stb;
  logic [TRIM_MAG_W:0] done_cnt;
  logic                corr_stb;
  logic                split_pend;
  logic                sec_stb;

  assign step = en_32k && !stop;

  osc_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .step(step),
    .raw_stb(raw_stb), .mid_stb(mid_stb)
  );

  trim_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .raw_stb(raw_stb),
    .cfg_in(trim_t'(trim_cfg)), .act(act), .cfg_act(cfg_act),
    .wrap_stb(wrap_stb), .done_cnt(done_cnt)
  );

  pulse_corrector u_corr (
    .clk(clk), .rst_n(rst_n), .raw_stb(raw_stb), .mid_stb(mid_stb),
    .act(act), .corr_stb(corr_stb), .split_pend(split_pend)
  );

  second_counter #(.DIV(POST_DIV)) u_sec (
    .clk(clk), .rst_n(rst_n), .pulse(corr_stb), .sec_stb(sec_stb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cal <= 1'b0;
      tick_1hz <= 1'b0;
    end else begin
      tick_cal <= corr_stb;
      tick_1hz <= sec_stb;
    end
  end
endmodule

// File: rtl/osc_trim_divider_chk.sv
module osc_trim_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_32k,
  input logic       stop,
  input logic       tick_1hz,
  input logic       tick_cal,
  input logic [5:0] cfg_act,
  input logic       wrap_stb,
  input logic [5:0] done_cnt,
  input logic       split_pend
);
  // R7: nothing is emitted after a stopped cycle
  a_r7_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop) |-> (!tick_cal && !tick_1hz));

  // R2: a pulse needs an enable in the previous cycle
  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_32k) |-> !tick_cal);

  // R9: the second tick rides on a corrected pulse
  a_r9_sec_with_cal: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |-> tick_cal);

  // R6: the active trim changes only after a window wrap
  a_r6_cfg_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_act) |-> $past(wrap_stb));

  // R3: corrections never exceed twice the active magnitude
  a_r3_budget: assert property (@(posedge clk) disable iff (!rst_n)
    done_cnt <= {cfg_act[4:0], 1'b0});

  // R5: a split is armed only by an active enable
  a_r5_split_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(split_pend) |-> ($past(en_32k) && !$past(stop)));
endmodule

bind osc_trim_divider osc_trim_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_32k(en_32k), .stop(stop),
  .tick_1hz(tick_1hz), .tick_cal(tick_cal), .cfg_act(cfg_act),
  .wrap_stb(wrap_stb), .done_cnt(done_cnt), .split_pend(split_pend)
);

// File: tb/tb_osc_trim_divider.sv
module tb_osc_trim_divider;
  localparam int PRE  = 4;
  localparam int POST = 8;
  localparam int WSEC = 8;
  localparam int WLEN = WSEC * POST;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       stop = 1'b0;
  logic [5:0] cfg = 6'd0;
  logic       tick_1hz;
  logic       tick_cal;

  int tests = 0;
  int fails = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  osc_trim_divider #(.PRE_DIV(PRE), .POST_DIV(POST), .WINDOW_SEC(WSEC)) dut (
    .clk(clk), .rst_n(rst_n), .en_32k(en), .stop(stop), .trim_cfg(cfg),
    .tick_1hz(tick_1hz), .tick_cal(tick_cal)
  );

  // behavioural reference
  int   m_ph = 0, m_widx = 0, m_done = 0, m_mag = 0, m_pulses = 0;
  bit   m_pos = 0, m_pend = 0, m_emit;
  logic exp_cal = 0, exp_sec = 0;

  always @(posedge clk) begin
    exp_cal = 0;
    exp_sec = 0;
    if (!rst_n) begin
      m_ph = 0; m_widx = 0; m_done = 0; m_mag = 0; m_pulses = 0;
      m_pos = 0; m_pend = 0;
    end else if (en && !stop) begin
      m_emit = 0;
      if (m_pend && m_ph == PRE / 2 - 1) begin
        m_emit = 1;
        m_pend = 0;
      end
      if (m_ph == PRE - 1) begin
        if (m_done < 2 * m_mag) begin
          m_done++;
          if (m_pos) begin
            m_pend = 1;
            m_emit = 1;
          end
        end else begin
          m_emit = 1;
        end
        m_widx++;
        if (m_widx == WLEN) begin
          m_widx = 0;
          m_done = 0;
          m_mag  = int'(cfg[4:0]);
          m_pos  = cfg[5];
        end
      end
      m_ph = (m_ph + 1) % PRE;
      if (m_emit) begin
        exp_cal  = 1;
        m_pulses = (m_pulses + 1) % POST;
        if (m_pulses == 0) exp_sec = 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  // wait for the next falling edge and compare against the model
  task automatic cycle();
    @(negedge clk);
    check("R2 R4 R5 R9 tick_cal vs model", int'(tick_cal), int'(exp_cal));
    check("R2 R9 tick_1hz vs model", int'(tick_1hz), int'(exp_sec));
  endtask

  int cal_win[3];
  int sec_win0;
  int cnt;
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset tick_cal", int'(tick_cal), 0);
    check("R8 reset tick_1hz", int'(tick_1hz), 0);
    rst_n = 1'b1;
    en    = 1'b1;
    cfg   = {1'b0, 5'd5};
    for (int i = 0; i < 3; i++) cal_win[i] = 0;
    sec_win0 = 0;
    for (int k = 1; k <= 3 * PRE * WLEN; k++) begin
      cycle();
      if (tick_cal) cal_win[(k - 1) / (PRE * WLEN)]++;
      if (tick_1hz && k <= PRE * WLEN) sec_win0++;
      if (k == 400) cfg = {1'b1, 5'd3};
    end
    check("R1 R6 first window uncorrected pulses", cal_win[0], WLEN);
    check("R1 seconds in first window", sec_win0, WLEN / POST);
    check("R4 R3 slow window pulses", cal_win[1], WLEN - 10);
    check("R5 R6 fast window pulses", cal_win[2], WLEN + 6);

    // R7: stop burst with enables present
    stop = 1'b1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      cycle();
      if (k > 0 && tick_cal) cnt++;
    end
    check("R7 no pulses while stopped", cnt, 0);
    stop = 1'b0;
    repeat (30) cycle();

    // R2: idle enable
    en = 1'b0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      cycle();
      if (k > 0 && tick_cal) cnt++;
    end
    check("R2 no pulses without enable", cnt, 0);

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      cycle();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en   = lfsr[0] | lfsr[3];
      stop = (lfsr[7:4] == 4'hF);
      if (k % 500 == 0) cfg = lfsr[13:8];
      if (k == 2000) rst_n = 1'b0;
      if (k == 2003) begin
        check("R8 mid-run reset tick_cal", int'(tick_cal), 0);
        check("R8 mid-run reset tick_1hz", int'(tick_1hz), 0);
        rst_n = 1'b1;
      end
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      done_flag = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule